// File: doc/BRIEF.md
# Serial-Programmed Level Code Bank

This block is the digital control core of a twenty-output, eight-bit voltage-setting converter. A host writes it over a slow three-wire serial port made of a serial clock, a data line and a load strobe. Each command frame holds an eight-bit level code and a five-bit target address. When the load strobe rises, the addressed frame is committed into one of sixteen plain level registers or into one of eight extension registers. The extension registers form two banks of four. A bank-select input chooses which bank feeds the four extension outputs. The block presents twenty eight-bit codes to the analog converters that follow it.

All four serial-side inputs are sampled by a system clock that runs at least twenty times faster than the serial clock. Each input passes through a two-flop synchronizer. The receiver is a three-state machine:

- `RX_COLLECT` gathers bits. It moves to `RX_READY` on the sixteenth serial clock rise. It moves to `RX_LATCH` on a load rise, and no write takes place.
- `RX_READY` holds a complete frame. Further serial clock rises keep shifting, so the most recent sixteen bits are kept. On a load rise it commits the frame and moves to `RX_LATCH`.
- `RX_LATCH` spans the load-high window. Serial edges are ignored here. A load fall returns the machine to `RX_COLLECT`.

The bit counter is cleared on every load rise.

While the machine is in `RX_LATCH`, the extension outputs track the bank-select input. Outside that window they keep the last bank choice.

Top module: `serial_level_bank`

## Requirements
- R1: After reset, all sixteen plain codes and all four extension codes read 00h.
- R2: Frames are shifted least-significant bit first, one bit per serial clock rise. The level code is frame bits 15..8, with bit 15 as its MSB. The address is frame bits 4..0.
- R3: Address values 1 to 16 write plain output 1 to 16. Plain output n appears on `plain_codes[(n-1)*8 +: 8]`.
- R4: Address values 17 to 20 write bank 0 of extension outputs 1 to 4. Address values 21 to 24 write bank 1 of the same outputs. Extension output n appears on `ext_codes[(n-1)*8 +: 8]`.
- R5: Address 0 and address values 25 to 31 write nothing, and no output changes.
- R6: Frame bits 7..5 have no effect on where the frame is written or what value is written.
- R7: If fewer than sixteen bits were received since the previous load rise, a load pulse writes nothing.
- R8: If more than sixteen bits are received before load, the last sixteen bits received form the frame.
- R9: A complete frame changes no output until load rises. While load is low, every output holds its value.
- R10: While load is high, the extension outputs show bank 1 when `bank_sel` is high and bank 0 when it is low. Once load falls, changes on `bank_sel` do not alter the extension outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20x the serial clock |
| rst_n | input | 1 | Active-low reset (power-on reset) |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_data | input | 1 | Serial data, LSB first |
| ser_load | input | 1 | Load strobe; a rise commits the frame, and high opens the transfer window |
| bank_sel | input | 1 | Extension bank choice: 0 selects bank 0, 1 selects bank 1 |
| plain_codes | output | 128 | Sixteen plain level codes, output 1 in the lowest byte |
| ext_codes | output | 32 | Four extension level codes from the selected bank |

## Verification
The embedded assertions check several properties on every cycle:
- The outputs stay frozen while load is low.
- The extension outputs do not move outside the load window.
- A no-operation address commits nothing.
- A commit only ever comes from a full sixteen-bit frame, and at most one register is written per commit.

Some behaviours can only be shown by the bench scenarios. These are the bit ordering and the address-to-output mapping across all 32 addresses, the handling of ignored bits, short and overlong frames, and the live bank switching during load-high.

// File: rtl/slb_pkg.sv
package slb_pkg;
    localparam int FRAME_W = 16;
    localparam int CODE_W  = 8;
    localparam int ADDR_W  = 5;
    localparam int CODE_LSB = FRAME_W - CODE_W;

    typedef enum logic [1:0] {
        RX_COLLECT,
        RX_READY,
        RX_LATCH
    } rx_state_e;
endpackage

// File: rtl/slb_sync.sv
module slb_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/slb_rx.sv
module slb_rx
    import slb_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s,
    input  logic          sdat_s,
    input  logic          load_s,
    output logic          commit,
    output logic          latch_win,
    output logic [FW-1:0] frame
);
    localparam int CNT_W = $clog2(FW + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FW - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FW);

    rx_state_e        state, state_d;
    logic [CNT_W-1:0] cnt;
    logic             sclk_q, load_q;
    logic             sclk_rise, load_rise, load_fall;

    assign sclk_rise = sclk_s & ~sclk_q;
    assign load_rise = load_s & ~load_q;
    assign load_fall = ~load_s & load_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_COLLECT;
        else        state <= state_d;
    end

    // next state
    always_comb begin
        state_d = state;
        unique case (state)
            RX_COLLECT: begin
                if (load_rise)                          state_d = RX_LATCH;
                else if (sclk_rise && cnt == LAST_BIT)  state_d = RX_READY;
            end
            RX_READY: begin
                if (load_rise) state_d = RX_LATCH;
            end
            RX_LATCH: begin
                if (load_fall) state_d = RX_COLLECT;
            end
            default: state_d = RX_COLLECT;
        endcase
    end

    // outputs
    always_comb begin
        commit    = 1'b0;
        latch_win = 1'b0;
        unique case (state)
            RX_READY:   commit    = load_rise;
            RX_LATCH:   latch_win = 1'b1;
            default:    ;
        endcase
    end

    // edge history, bit counter, shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            load_q <= 1'b0;
            cnt    <= '0;
            frame  <= '0;
        end else begin
            sclk_q <= sclk_s;
            load_q <= load_s;
            if (load_rise) begin
                cnt <= '0;
            end else if (sclk_rise && state != RX_LATCH && cnt != FULL_CNT) begin
                cnt <= cnt + 1'b1;
            end
            if (sclk_rise && state != RX_LATCH) begin
                frame <= {sdat_s, frame[FW-1:1]};
            end
        end
    end

    // R7: the ready state is only reached with a full frame counted
    a_r7_ready_full: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_READY) |-> (cnt == FULL_CNT));

    // R7: the counter never passes the frame length
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_CNT);
endmodule

// File: rtl/slb_bank.sv
module slb_bank
    import slb_pkg::*;
#(
    parameter int NUM_PLAIN = 16,
    parameter int NUM_EXT   = 4,
    parameter int CW        = CODE_W,
    parameter int AW        = ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit,
    input  logic                    latch_win,
    input  logic                    sel_s,
    input  logic [CW-1:0]           code,
    input  logic [AW-1:0]           addr,
    output logic [NUM_PLAIN*CW-1:0] plain_codes,
    output logic [NUM_EXT*CW-1:0]   ext_codes
);
    localparam int EXT_BASE = NUM_PLAIN + 1;
    localparam int NUM_EXT2 = 2 * NUM_EXT;
    localparam int LAST_ADR = NUM_PLAIN + NUM_EXT2;

    logic [NUM_PLAIN-1:0]     plain_we;
    logic [NUM_EXT2-1:0]      ext_we;
    logic [NUM_PLAIN*CW-1:0]  plain_q;
    logic [NUM_EXT2*CW-1:0]   ext_q;
    logic                     sel_hold;
    logic                     noop_adr;

    assign noop_adr = (addr == '0) || (int'(addr) > LAST_ADR);

    for (genvar i = 0; i < NUM_PLAIN; i++) begin : g_plain_dec
        assign plain_we[i] = commit && (addr == AW'(i + 1));
    end

    for (genvar j = 0; j < NUM_EXT2; j++) begin : g_ext_dec
        assign ext_we[j] = commit && (addr == AW'(EXT_BASE + j));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            plain_q  <= '0;
            ext_q    <= '0;
            sel_hold <= 1'b0;
        end else begin
            for (int i = 0; i < NUM_PLAIN; i++) begin
                if (plain_we[i]) plain_q[i*CW +: CW] <= code;
            end
            for (int j = 0; j < NUM_EXT2; j++) begin
                if (ext_we[j]) ext_q[j*CW +: CW] <= code;
            end
            if (latch_win) sel_hold <= sel_s;
        end
    end

    assign plain_codes = plain_q;

    for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext_mux
        assign ext_codes[e*CW +: CW] = sel_hold ? ext_q[(NUM_EXT + e)*CW +: CW]
                                                : ext_q[e*CW +: CW];
    end

    // R3, R4: one commit writes at most one register
    a_r3_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ext_we, plain_we}));

    // R5: a no-operation address leaves every output unchanged
    a_r5_noop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && noop_adr) |=> ($stable(plain_codes) && $stable(ext_codes)));

    // R10: outside the load window with no commit the extension outputs hold
    a_r10_ext_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_win && !commit) |=> $stable(ext_codes));
endmodule

// File: rtl/serial_level_bank.sv
module serial_level_bank
    import slb_pkg::*;
#(
    parameter int NUM_PLAIN = 16,
    parameter int NUM_EXT   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ser_clk,
    input  logic                        ser_data,
    input  logic                        ser_load,
    input  logic                        bank_sel,
    output logic [NUM_PLAIN*CODE_W-1:0] plain_codes,
    output logic [NUM_EXT*CODE_W-1:0]   ext_codes
);
    logic [3:0]         pins_s;
    logic               sclk_s, sdat_s, load_s, sel_s;
    logic               commit, latch_win;
    logic [FRAME_W-1:0] frame;

    slb_sync #(.W(4)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bank_sel, ser_load, ser_data, ser_clk}),
        .q     (pins_s)
    );

    assign sclk_s = pins_s[0];
    assign sdat_s = pins_s[1];
    assign load_s = pins_s[2];
    assign sel_s  = pins_s[3];

    slb_rx #(.FW(FRAME_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_s),
        .sdat_s    (sdat_s),
        .load_s    (load_s),
        .commit    (commit),
        .latch_win (latch_win),
        .frame     (frame)
    );

    slb_bank #(
        .NUM_PLAIN (NUM_PLAIN),
        .NUM_EXT   (NUM_EXT),
        .CW        (CODE_W),
        .AW        (ADDR_W)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .latch_win   (latch_win),
        .sel_s       (sel_s),
        .code        (frame[FRAME_W-1:CODE_LSB]),
        .addr        (frame[ADDR_W-1:0]),
        .plain_codes (plain_codes),
        .ext_codes   (ext_codes)
    );

    // R9: with load low, plain outputs cannot change on the next cycle
    a_r9_plain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_s |=> $stable(plain_codes));

    // R9: a commit only happens inside a load-high sample
    a_r9_commit_in_load: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> load_s);
endmodule

// File: tb/serial_level_bank_test.sv
module serial_level_bank_test;
    localparam int HALF = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_clk = 1'b0;
    logic         ser_data = 1'b0;
    logic         ser_load = 1'b0;
    logic         bank_sel = 1'b0;
    logic [127:0] plain_codes;
    logic [31:0]  ext_codes;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] m_plain [16];
    logic [7:0] m_ext   [8];
    logic       m_sel = 1'b0;

    always #2 clk = ~clk;

    serial_level_bank uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_clk     (ser_clk),
        .ser_data    (ser_data),
        .ser_load    (ser_load),
        .bank_sel    (bank_sel),
        .plain_codes (plain_codes),
        .ext_codes   (ext_codes)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int idx, input logic [7:0] act,
                         input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s output %0d: actual %02h expected %02h", tag, idx, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 16; i++) check(tag, i + 1, plain_codes[i*8 +: 8], m_plain[i]);
        for (int e = 0; e < 4; e++)
            check(tag, 17 + e, ext_codes[e*8 +: 8], m_sel ? m_ext[4 + e] : m_ext[e]);
    endtask

    function automatic logic [15:0] mk_frame(input logic [7:0] code, input logic [2:0] junk,
                                             input logic [4:0] adr);
        return {code, junk, adr};
    endfunction

    task automatic drive_bits(input logic [15:0] v, input int n);
        for (int k = 0; k < n; k++) begin
            ser_data = v[k];
            wait_clk(HALF);
            ser_clk = 1'b1;
            wait_clk(HALF);
            ser_clk = 1'b0;
        end
    endtask

    task automatic pulse_load();
        wait_clk(HALF);
        ser_load = 1'b1;
        wait_clk(24);
        ser_load = 1'b0;
        wait_clk(24);
    endtask

    task automatic model_write(input logic [4:0] adr, input logic [7:0] code);
        if (adr >= 5'd1 && adr <= 5'd16)       m_plain[adr - 5'd1] = code;
        else if (adr >= 5'd17 && adr <= 5'd24) m_ext[adr - 5'd17] = code;
    endtask

    task automatic send_frame(input logic [7:0] code, input logic [2:0] junk,
                              input logic [4:0] adr);
        drive_bits(mk_frame(code, junk, adr), 16);
        pulse_load();
        model_write(adr, code);
        m_sel = bank_sel;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) m_plain[i] = 8'h00;
        for (int i = 0; i < 8; i++)  m_ext[i] = 8'h00;
        wait_clk(10);
        rst_n = 1'b1;
        wait_clk(10);
        check_all("R1 reset");

        // R3 R4 R5 R6: all 32 addresses with varying ignored bits
        for (int a = 0; a < 32; a++) begin
            logic [7:0] c;
            c = 8'((a * 7 + 3) & 8'hFF);
            send_frame(c, 3'(a) ^ 3'b101, 5'(a));
            if (a == 0 || a > 24)      check_all("R5 noop address");
            else if (a <= 16)          check_all("R3 plain address");
            else                       check_all("R4 extension address");
        end

        // R2: bit-order patterns across all write targets
        for (int k = 0; k < 48; k++) begin
            logic [7:0] c;
            c = (k < 8) ? 8'(1 << k) : ((k % 3 == 0) ? 8'hA5 : 8'(k * 37 + 1));
            send_frame(c, 3'b000, 5'((k % 24) + 1));
            check_all("R2 code bit order");
        end

        // R6: ignored bits swept on one address
        for (int j = 0; j < 8; j++) begin
            send_frame(8'(j * 33 + 9), 3'(j), 5'd5);
            check_all("R6 ignored bits");
        end

        // R7: short frames write nothing
        drive_bits(mk_frame(8'hEE, 3'b000, 5'd3), 10);
        pulse_load();
        check_all("R7 ten-bit frame");
        drive_bits(mk_frame(8'hEE, 3'b000, 5'd3), 15);
        pulse_load();
        check_all("R7 fifteen-bit frame");

        // R8: leading surplus bits are pushed out
        drive_bits(16'hFFFF, 5);
        send_frame(8'h6D, 3'b010, 5'd9);
        check_all("R8 overlong frame");

        // R9: nothing moves until load rises
        drive_bits(mk_frame(8'h3C, 3'b000, 5'd2), 16);
        wait_clk(40);
        check_all("R9 before load");
        pulse_load();
        model_write(5'd2, 8'h3C);
        check_all("R9 after load");

        // R10: bank select behaviour
        bank_sel = 1'b1;
        wait_clk(20);
        check_all("R10 sel change with load low");
        send_frame(8'h00, 3'b000, 5'd0);
        check_all("R10 bank 1 after load");
        bank_sel = 1'b0;
        wait_clk(20);
        check_all("R10 frozen on bank 1");
        drive_bits(mk_frame(8'h00, 3'b000, 5'd31), 16);
        wait_clk(HALF);
        ser_load = 1'b1;
        wait_clk(20);
        m_sel = 1'b0;
        check_all("R10 follow bank 0 in load high");
        bank_sel = 1'b1;
        wait_clk(20);
        m_sel = 1'b1;
        check_all("R10 follow bank 1 in load high");
        bank_sel = 1'b0;
        wait_clk(20);
        m_sel = 1'b0;
        check_all("R10 follow back to bank 0");
        ser_load = 1'b0;
        wait_clk(20);
        bank_sel = 1'b1;
        wait_clk(20);
        check_all("R10 frozen after load fall");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule